// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block stores incoming frames in a circular receive area made of 256-byte pages in an external byte-wide RAM. A frame arrives as a byte stream with start-of-frame and end-of-frame markers, one byte per valid cycle. The block writes the payload four bytes into the current page. It pads short frames with zeros. When the write address reaches the stop page it continues at the start page. After the payload it fills in a four-byte descriptor at the start of the frame's first page. The descriptor gives the status, the page where the following frame will begin, and the stored length.

The surrounding controller owns the ring registers: the start page, stop page, boundary page and current page, and the stop bit of its command register. The block tells it through `can_accept` whether a new frame fits. When a frame is complete, the block returns the new current page and raises a one-cycle receive-OK pulse, which the controller uses to set its interrupt status bit.

Top module: `rx_ring_writer`

## Requirements
- R1: `can_accept` is 1 only when `halt` is 0 and the free space is at least 1518 bytes. Free space is (bound_pg − cur_pg)·256 when cur_pg < bound_pg, and otherwise ((last_pg − first_pg) − (cur_pg − bound_pg))·256. A start-of-frame byte that arrives while `can_accept` is 0 is dropped together with the rest of its frame.
- R2: The byte accepted at the start of a frame is written to address cur_pg·256 + 4. Each later payload byte goes to the next address. Each RAM write appears on the port in the cycle after its byte is accepted.
- R3: When a payload address reaches last_pg·256, writing continues at first_pg·256.
- R4: A frame shorter than 60 bytes is extended with zero bytes up to 60 bytes.
- R5: The header sits at addresses base+0 to base+3, where base is the frame's first page times 256. Byte 0 is the status, byte 1 is the next page, and bytes 2 and 3 are the stored length, low byte first. The stored length is the padded length plus 4.
- R6: The status byte is 0x01, with bit 5 also set when bit 0 of the frame's first byte is 1.
- R7: The next page is base page + floor((stored length + 4 + 255) / 256). When that value is last_pg or above, (last_pg − first_pg) is subtracted from it.
- R8: The four header bytes are written only after every payload byte and padding byte of the frame has been written.
- R9: In the same cycle as the last header write, `cur_pg_next` takes the next page and `rx_ok` is high. `rx_ok` is high for that one cycle only.
- R10: `busy` is 1 from the cycle after a frame is accepted until the frame completes. Stream bytes that arrive while padding or while the header is being written are ignored. So are bytes without a start marker that arrive while idle.
- R11: After a synchronous reset (`rst_n` low), `busy`, `ram_we` and `rx_ok` are 0 and `cur_pg_next` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| halt | input | 1 | Stop bit of the command register; while it is set, no frame is accepted |
| first_pg | input | 8 | First page of the ring |
| last_pg | input | 8 | Page just past the end of the ring |
| bound_pg | input | 8 | Boundary page, the oldest page not yet read out |
| cur_pg | input | 8 | Current page, where the next frame will start |
| in_valid | input | 1 | Stream byte valid |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| in_data | input | 8 | Stream byte |
| can_accept | output | 1 | A new frame would be accepted |
| busy | output | 1 | A frame is being stored |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| cur_pg_next | output | 8 | Current page after the last completed frame |
| rx_ok | output | 1 | One-cycle pulse: frame stored |

## Verification
`can_accept` depends only on the current inputs, so the bench samples it one half-cycle after the inputs change. Every RAM write is registered: the write for a byte accepted at edge k is valid between edges k and k+1. The bench records `ram_we` and its address and data at each falling edge, so it catches each write in its cycle. Padding takes one cycle per missing byte and the header takes four cycles. The last header write, `rx_ok` and `cur_pg_next` all appear together after the final edge. The bench therefore waits for `rx_ok` at falling edges and waits one more falling edge before it inspects the captured RAM image. The recorded write order is used to check that the header comes last.

// File: rtl/rxr_pkg.sv
// Shared types and constants for the receive ring frame writer.
package rxr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_PAD  = 2'd2,
        ST_HDR  = 2'd3
    } rxr_state_e;

    localparam logic [7:0] RX_STAT_OK  = 8'h01;
    localparam int         GROUP_BIT   = 5;
    localparam int         MIN_FRAME   = 60;
    localparam int         HDR_BYTES   = 4;
    localparam int         CRC_BYTES   = 4;
    localparam int         MAX_FRAME   = 1514;
    localparam int         NEED_BYTES  = MAX_FRAME + CRC_BYTES;
endpackage

// File: rtl/rxr_space_chk.sv
// Free-space check for the receive ring.
// Works out how many bytes lie between the current page and the boundary
// page, going round the ring, and reports whether a maximum-size frame fits.
// Assumes first_pg < last_pg and that cur_pg and bound_pg lie inside the ring.
module rxr_space_chk #(
    parameter int PG_W       = 8,
    parameter int NEED_BYTES = 1518
) (
    input  logic            halt,
    input  logic [PG_W-1:0] first_pg,
    input  logic [PG_W-1:0] last_pg,
    input  logic [PG_W-1:0] bound_pg,
    input  logic [PG_W-1:0] cur_pg,
    output logic            can_accept
);
    localparam int SW = PG_W + 10;
    localparam logic signed [SW-1:0] NEED_S = SW'(NEED_BYTES);

    logic signed [SW-1:0] free_pg;
    logic signed [SW-1:0] free_bytes;

    // Pages free from current up to boundary, round the ring if needed.
    always_comb begin
        if (cur_pg < bound_pg)
            free_pg = $signed(SW'(bound_pg)) - $signed(SW'(cur_pg));
        else
            free_pg = ($signed(SW'(last_pg)) - $signed(SW'(first_pg)))
                    - ($signed(SW'(cur_pg)) - $signed(SW'(bound_pg)));
        free_bytes = free_pg <<< 8;
        can_accept = !halt && (free_bytes >= NEED_S);
    end
endmodule

// File: rtl/rxr_link_calc.sv
// Next-page calculation for a stored frame.
// Rounds the stored length plus the checksum allowance up to whole pages,
// adds them to the frame's base page and folds the result back into the ring.
// Assumes the frame is shorter than the ring.
module rxr_link_calc #(
    parameter int PG_W      = 8,
    parameter int LEN_W     = 16,
    parameter int CRC_BYTES = 4
) (
    input  logic [PG_W-1:0]  base_pg,
    input  logic [PG_W-1:0]  first_pg,
    input  logic [PG_W-1:0]  last_pg,
    input  logic [LEN_W-1:0] stored_len,
    output logic [PG_W-1:0]  next_pg
);
    localparam int W = ((LEN_W > PG_W) ? LEN_W : PG_W) + 2;

    logic [W-1:0] span;
    logic [W-1:0] pages;
    logic [W-1:0] raw;

    // Round up to pages, step forward, subtract the ring size on overrun.
    always_comb begin
        span  = W'(stored_len) + W'(CRC_BYTES) + W'(255);
        pages = span >> 8;
        raw   = W'(base_pg) + pages;
        if (raw >= W'(last_pg))
            raw = raw - (W'(last_pg) - W'(first_pg));
        next_pg = raw[PG_W-1:0];
    end
endmodule

// File: rtl/rxr_wrap_ptr.sv
// Payload write pointer.
// Holds the address for the next payload byte. It is loaded at frame start
// and moves up by one per step, jumping from the stop page to the start page.
// Assumes first_pg < last_pg.
module rxr_wrap_ptr #(
    parameter int PG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PG_W+7:0]   load_addr,
    input  logic              step,
    input  logic [PG_W-1:0]   first_pg,
    input  logic [PG_W-1:0]   last_pg,
    output logic [PG_W+7:0]   ptr
);
    localparam int ADDR_W = PG_W + 8;

    logic [ADDR_W-1:0] inc;

    // Next address, wrapped at the stop page.
    always_comb begin
        inc = ptr + 1'b1;
        if (inc == {last_pg, 8'h00})
            inc = {first_pg, 8'h00};
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= load_addr;
        else if (step)
            ptr <= inc;
    end

    // R3
    ptr_never_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && $stable(last_pg)) |=> (ptr != {last_pg, 8'h00}));
endmodule

// File: rtl/rx_ring_writer.sv
// Receive ring frame writer (top).
// Takes a byte stream with frame markers and writes the payload, the zero
// padding and then the 4-byte header into a paged ring in external RAM.
// It reports the new current page with a one-cycle receive-OK pulse.
// Assumes one byte per valid cycle and a sane ring configuration that stays
// stable while busy. The caller stops sending while busy.
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int PG_W  = 8,
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic [PG_W-1:0]   first_pg,
    input  logic [PG_W-1:0]   last_pg,
    input  logic [PG_W-1:0]   bound_pg,
    input  logic [PG_W-1:0]   cur_pg,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [7:0]        in_data,
    output logic              can_accept,
    output logic              busy,
    output logic              ram_we,
    output logic [PG_W+7:0]   ram_addr,
    output logic [7:0]        ram_wdata,
    output logic [PG_W-1:0]   cur_pg_next,
    output logic              rx_ok
);
    localparam int ADDR_W = PG_W + 8;
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] HDR_L = LEN_W'(HDR_BYTES);

    rxr_state_e        state;
    logic [LEN_W-1:0]  count;
    logic [LEN_W-1:0]  cnt_inc;
    logic [LEN_W-1:0]  stored_len;
    logic [PG_W-1:0]   base_pg;
    logic              group_hit;
    logic [1:0]        hdr_idx;
    logic [PG_W-1:0]   link_pg;
    logic [ADDR_W-1:0] ptr;
    logic              take_sof;
    logic              ptr_step;
    logic [7:0]        stat_byte;
    logic [7:0]        hdr_byte;

    rxr_space_chk #(.PG_W(PG_W), .NEED_BYTES(NEED_BYTES)) u_space (
        .halt       (halt),
        .first_pg   (first_pg),
        .last_pg    (last_pg),
        .bound_pg   (bound_pg),
        .cur_pg     (cur_pg),
        .can_accept (can_accept)
    );

    rxr_link_calc #(.PG_W(PG_W), .LEN_W(LEN_W), .CRC_BYTES(CRC_BYTES)) u_link (
        .base_pg    (base_pg),
        .first_pg   (first_pg),
        .last_pg    (last_pg),
        .stored_len (stored_len),
        .next_pg    (link_pg)
    );

    rxr_wrap_ptr #(.PG_W(PG_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take_sof),
        .load_addr ({cur_pg, 8'(HDR_BYTES + 1)}),
        .step      (ptr_step),
        .first_pg  (first_pg),
        .last_pg   (last_pg),
        .ptr       (ptr)
    );

    // Frame-start acceptance, pointer step and header byte selection.
    always_comb begin
        take_sof   = (state == ST_IDLE) && in_valid && in_sof && can_accept;
        ptr_step   = ((state == ST_DATA) && in_valid) || (state == ST_PAD);
        cnt_inc    = count + 1'b1;
        stored_len = count + HDR_L;
        stat_byte  = RX_STAT_OK;
        stat_byte[GROUP_BIT] = group_hit;
        case (hdr_idx)
            2'd0:    hdr_byte = stat_byte;
            2'd1:    hdr_byte = 8'(link_pg);
            2'd2:    hdr_byte = stored_len[7:0];
            default: hdr_byte = stored_len[15:8];
        endcase
        busy = (state != ST_IDLE);
    end

    // Frame sequencer: payload, padding, then header, then completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            count       <= '0;
            base_pg     <= '0;
            group_hit   <= 1'b0;
            hdr_idx     <= 2'd0;
            ram_we      <= 1'b0;
            ram_addr    <= '0;
            ram_wdata   <= '0;
            cur_pg_next <= '0;
            rx_ok       <= 1'b0;
        end else begin
            ram_we <= 1'b0;
            rx_ok  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (take_sof) begin
                        ram_we    <= 1'b1;
                        ram_addr  <= {cur_pg, 8'(HDR_BYTES)};
                        ram_wdata <= in_data;
                        base_pg   <= cur_pg;
                        group_hit <= in_data[0];
                        count     <= LEN_W'(1);
                        hdr_idx   <= 2'd0;
                        state     <= in_eof ? ST_PAD : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (in_valid) begin
                        ram_we    <= 1'b1;
                        ram_addr  <= ptr;
                        ram_wdata <= in_data;
                        count     <= cnt_inc;
                        if (in_eof)
                            state <= (cnt_inc < MIN_L) ? ST_PAD : ST_HDR;
                    end
                end
                ST_PAD: begin
                    ram_we    <= 1'b1;
                    ram_addr  <= ptr;
                    ram_wdata <= 8'h00;
                    count     <= cnt_inc;
                    if (cnt_inc >= MIN_L)
                        state <= ST_HDR;
                end
                default: begin
                    ram_we    <= 1'b1;
                    ram_addr  <= {base_pg, 6'd0, hdr_idx};
                    ram_wdata <= hdr_byte;
                    hdr_idx   <= hdr_idx + 2'd1;
                    if (hdr_idx == 2'd3) begin
                        cur_pg_next <= link_pg;
                        rx_ok       <= 1'b1;
                        state       <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // R1
    reject_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && in_valid && in_sof && !can_accept) |=> !ram_we);
    // R9
    ok_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok |=> !rx_ok);
    // R8
    ok_with_last_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok |-> (ram_we && ram_addr[1:0] == 2'd3 && !busy));
    // R7
    link_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ok && first_pg < last_pg) |-> (cur_pg_next >= first_pg && cur_pg_next < last_pg));
    // R10
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && in_valid && in_sof && can_accept) |=> busy);
endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
    typedef struct packed {
        logic [7:0]  first;
        logic [7:0]  last;
        logic [7:0]  cur;
        logic [7:0]  bound;
        logic [15:0] len;
        logic [7:0]  b0;
    } vec_t;

    // first, last, cur, bound, frame length, first byte
    localparam vec_t VECS [8] = '{
        '{8'd1, 8'd16, 8'd1,  8'd1,  16'd100,  8'h00},
        '{8'd1, 8'd16, 8'd4,  8'd1,  16'd20,   8'h01},
        '{8'd2, 8'd8,  8'd7,  8'd7,  16'd300,  8'h10},
        '{8'd0, 8'd16, 8'd3,  8'd3,  16'd1514, 8'h03},
        '{8'd0, 8'd16, 8'd10, 8'd2,  16'd248,  8'h02},
        '{8'd0, 8'd16, 8'd10, 8'd2,  16'd249,  8'h00},
        '{8'd0, 8'd16, 8'd15, 8'd15, 16'd60,   8'h01},
        '{8'd4, 8'd12, 8'd11, 8'd11, 16'd1,    8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt = 1'b0;
    logic [7:0]  first_pg = 8'd0, last_pg = 8'd16, bound_pg = 8'd0, cur_pg = 8'd0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        can_accept, busy, ram_we, rx_ok;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  cur_pg_next;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int seq = 0;
    int we_count = 0;
    int max_body_seq, min_hdr_seq;
    logic [15:0] hdr_base;
    logic [7:0]  bmem [0:4095];

    always #10 clk = ~clk;

    rx_ring_writer u_rx_ring_writer (
        .clk(clk), .rst_n(rst_n), .halt(halt),
        .first_pg(first_pg), .last_pg(last_pg), .bound_pg(bound_pg), .cur_pg(cur_pg),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .can_accept(can_accept), .busy(busy), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .cur_pg_next(cur_pg_next), .rx_ok(rx_ok)
    );

    // Capture RAM writes away from the active edge.
    always @(negedge clk) begin
        if (ram_we) begin
            bmem[ram_addr[11:0]] = ram_wdata;
            seq = seq + 1;
            we_count = we_count + 1;
            if (ram_addr >= hdr_base && ram_addr < hdr_base + 16'd4) begin
                if (seq < min_hdr_seq) min_hdr_seq = seq;
            end else if (seq > max_body_seq) max_body_seq = seq;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input logic [7:0] b0);
        return (i == 0) ? b0 : 8'((i * 7 + 3) & 8'hff);
    endfunction

    function automatic logic [7:0] exp_next(input vec_t v);
        int padded = (v.len < 60) ? 60 : int'(v.len);
        int n = int'(v.cur) + (padded + 4 + 4 + 255) / 256;
        if (n >= int'(v.last)) n = n - (int'(v.last) - int'(v.first));
        return 8'(n);
    endfunction

    task automatic run_frame(input vec_t v, input string tag);
        int padded = (v.len < 60) ? 60 : int'(v.len);
        int base = int'(v.cur) * 256;
        int bad = 0, bad_i = -1, bad_a = 0, bad_e = 0;
        int okc = 0, wait_n = 0, busy_bad = 0;
        logic [7:0] st;
        for (int a = 0; a < 4096; a++) bmem[a] = 8'hA5;
        @(negedge clk);
        first_pg = v.first; last_pg = v.last; cur_pg = v.cur; bound_pg = v.bound;
        hdr_base = 16'(base); max_body_seq = 0; min_hdr_seq = 32'h7fffffff;
        @(negedge clk);
        check({"R1 accept ", tag}, int'(can_accept), 1);
        for (int i = 0; i < int'(v.len); i++) begin
            in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == int'(v.len) - 1);
            in_data = pat(i, v.b0);
            @(negedge clk);
            if (!busy) busy_bad++;
        end
        // junk while padding / header: must be ignored (R10)
        in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'hEE;
        while (!rx_ok && wait_n < 4000) begin
            if (!busy) busy_bad++;
            @(negedge clk); wait_n++;
        end
        okc = int'(rx_ok);
        check({"R9 cur_pg_next ", tag}, int'(cur_pg_next), int'(exp_next(v)));
        check({"R7 next page ", tag}, int'(cur_pg_next), int'(exp_next(v)));
        @(negedge clk);
        okc += int'(rx_ok);
        in_valid = 1'b0;
        check({"R9 one pulse ", tag}, okc, 1);
        check({"R10 busy during frame ", tag}, busy_bad, 0);
        check({"R10 idle after ", tag}, int'(busy), 0);
        for (int i = 0; i < padded; i++) begin
            int a = base + 4 + i;
            logic [7:0] e = (i < int'(v.len)) ? pat(i, v.b0) : 8'h00;
            if (a >= int'(v.last) * 256) a = a - (int'(v.last) - int'(v.first)) * 256;
            if (bmem[a] !== e) begin
                bad++;
                if (bad_i < 0) begin bad_i = i; bad_a = int'(bmem[a]); bad_e = int'(e); end
            end
        end
        if (bad != 0) $display("  first mismatch at byte %0d", bad_i);
        check({"R2 R3 R4 payload ", tag}, bad_a, bad_e);
        st = 8'h01 | (v.b0[0] ? 8'h20 : 8'h00);
        check({"R6 status ", tag}, int'(bmem[base]), int'(st));
        check({"R5 next byte ", tag}, int'(bmem[base + 1]), int'(exp_next(v)));
        check({"R5 length ", tag}, int'({bmem[base + 3], bmem[base + 2]}), padded + 4);
        check({"R8 header last ", tag}, int'(min_hdr_seq > max_body_seq), 1);
    endtask

    initial begin
        int w0;
        hdr_base = 16'hFFF0; max_body_seq = 0; min_hdr_seq = 32'h7fffffff;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 busy", int'(busy), 0);
        check("R11 ram_we", int'(ram_we), 0);
        check("R11 rx_ok", int'(rx_ok), 0);
        check("R11 cur_pg_next", int'(cur_pg_next), 0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VECS[k]) run_frame(VECS[k], $sformatf("vec%0d", k));

        // R1 space boundaries
        first_pg = 8'd0; last_pg = 8'd16; cur_pg = 8'd5; bound_pg = 8'd10;
        @(negedge clk); check("R1 five pages free", int'(can_accept), 0);
        cur_pg = 8'd4;
        @(negedge clk); check("R1 six pages free", int'(can_accept), 1);
        cur_pg = 8'd12; bound_pg = 8'd2;
        @(negedge clk); check("R1 wrapped six free", int'(can_accept), 1);
        bound_pg = 8'd1;
        @(negedge clk); check("R1 wrapped five free", int'(can_accept), 0);

        // R1 halt blocks a frame that would otherwise fit
        cur_pg = 8'd3; bound_pg = 8'd3; halt = 1'b1;
        @(negedge clk); check("R1 halt", int'(can_accept), 0);
        w0 = we_count;
        for (int i = 0; i < 10; i++) begin
            in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == 9); in_data = 8'h11;
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (80) @(negedge clk);
        check("R1 halted frame writes", we_count - w0, 0);
        check("R10 halted frame busy", int'(busy), 0);
        halt = 1'b0;

        // R10 bytes without start marker while idle
        w0 = we_count;
        for (int i = 0; i < 8; i++) begin
            in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 7); in_data = 8'h22;
            @(negedge clk);
        end
        in_valid = 1'b0; in_eof = 1'b0;
        repeat (10) @(negedge clk);
        check("R10 idle junk writes", we_count - w0, 0);
        check("R9 cur_pg_next held", int'(cur_pg_next), int'(exp_next(VECS[7])));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule